// File: doc/BRIEF.md
# Parallel DAC Write Strobe Sequencer

This block sits on the host side of a group of double-buffered 16-bit converters that share a parallel data bus. Each converter has two stages. The first-stage latch holds a new word. The second-stage latch drives the converter. A single write strobe and a single clear line are shared by all devices. The sequencer takes one command at a time over a valid/ready handshake. It then generates the bus word, the active-low stage enables for each device, the active-low write strobe and the active-low clear pulse. Setup, strobe width, hold and clear width are each counted in system clock cycles.

Every interface time is a parameter given in picoseconds, and the clock period is a parameter too. Each time is converted to a cycle count by dividing and rounding up, with a minimum of one cycle. A write runs in three phases: setup (bus and enables driven, strobe high), strobe (strobe low) and hold (strobe high again, bus and enables still driven). After the hold phase the sequencer returns to idle. A broadcast update loads each device's first stage in turn. It then strobes the second stage of every device at once, so all outputs change together. Commands that arrive while a sequence runs wait on `cmd_ready`. A clear never cuts a running write short.

Top module: `dac_strobe_seq`

## Requirements
- R1: After reset, and in idle, `strobe_n`, `clear_n`, every bit of `stage1_en_n` and `stage2_en_n` are 1, `bus_data` is 0 and `cmd_ready` is 1.
- R2: Each phase length in cycles is ceil(time_ps / CLK_PS), at least 1. With the defaults (5000 ps clock) this gives setup 10, double-buffered strobe 10, single-buffered strobe 16, hold 2 and clear 40 cycles. A phase always runs its full length.
- R3: Opcode 0 (load) pulls `stage1_en_n[cmd_dev]` low for setup+strobe+hold cycles. `strobe_n` is low only for the strobe-phase cycles, which follow the setup cycles.
- R4: Opcode 1 (update) does the same with `stage2_en_n[cmd_dev]`, and `stage1_en_n` stays all ones.
- R5: Opcode 2 (single-buffered write) pulls both enables of `cmd_dev` low and uses the longer strobe count.
- R6: Opcode 4 (broadcast) loads devices 0 to NDEV-1 in ascending order. Device i receives `cmd_bcast_words[i*DW +: DW]`, and each load is a full setup/strobe/hold sequence. A final sequence follows with every `stage2_en_n` bit low, `stage1_en_n` all ones and the bus at 0. At most one `stage1_en_n` bit is ever low.
- R7: Opcode 3 (clear) holds `clear_n` low for the clear count. Enables and strobe stay inactive and the bus stays 0.
- R8: `cmd_ready` is 0 from the cycle after acceptance until the sequence ends. A command held valid during a sequence does not alter that sequence. It is accepted in the first idle cycle, and its first phase starts in the next cycle. This also holds for a clear.
- R9: Opcodes 5, 6 and 7 are accepted and produce no activity on any output pin.
- R10: During all three phases of a load, update or single write, `bus_data` carries `cmd_word`. The bus, the enables and the strobe do not change on the cycle in which `strobe_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_op | input | 3 | Opcode: 0 load, 1 update, 2 single, 3 clear, 4 broadcast |
| cmd_dev | input | DEVW | Target device index |
| cmd_word | input | DW | Word for load or single write |
| cmd_bcast_words | input | NDEV*DW | Per-device words for broadcast, device i at bits i*DW |
| bus_data | output | DW | Shared converter data bus |
| stage1_en_n | output | NDEV | Active-low first-stage enables, one per device |
| stage2_en_n | output | NDEV | Active-low second-stage enables, one per device |
| strobe_n | output | 1 | Active-low shared write strobe |
| clear_n | output | 1 | Active-low shared clear pulse |

## Verification
The bench compares every output pin in every cycle of a command against a trace computed from the phase lengths. It covers load, update and single writes to each of the four devices, using different words including both half-scale boundary codes, which shows whether enable steering and the choice of strobe length are correct. Two broadcasts with different word sets show the load order, the slice selection and the shared final update. A clear, the three unused opcodes, and commands held valid while another runs test the clear width, the absence of side effects, back-pressure, and the exact cycle in which a queued command starts.

// File: rtl/dac_seq_pkg.sv
`timescale 1ns/1ps
package dac_seq_pkg;

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_UPDATE = 3'd1,
    OP_SINGLE = 3'd2,
    OP_CLEAR  = 3'd3,
    OP_BCAST  = 3'd4
  } seq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_CLEAR
  } seq_state_e;

  // time in ps -> cycles, rounded up, never below one
  function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                               input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/dac_seq_timer.sv
`timescale 1ns/1ps
module dac_seq_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R2: a new phase is only loaded once the previous one has fully elapsed
  p_phase_full_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> done);

endmodule

// File: rtl/dac_seq_pins.sv
`timescale 1ns/1ps
module dac_seq_pins
  import dac_seq_pkg::*;
#(
  parameter int unsigned NDEV = 4,
  parameter int unsigned DW   = 16,
  parameter int unsigned DEVW = 2
) (
  input  seq_state_e          state,
  input  logic [2:0]          op,
  input  logic [DEVW-1:0]     dev,
  input  logic [DEVW-1:0]     idx,
  input  logic                upd_phase,
  input  logic [DW-1:0]       word,
  input  logic [NDEV*DW-1:0]  bwords,
  output logic [DW-1:0]       bus_data,
  output logic [NDEV-1:0]     stage1_en_n,
  output logic [NDEV-1:0]     stage2_en_n,
  output logic                strobe_n,
  output logic                clear_n
);

  logic            active;
  logic [NDEV-1:0] dev_sel, idx_sel, s1, s2;
  logic [DW-1:0]   data;

  assign active  = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign dev_sel = NDEV'(1) << dev;
  assign idx_sel = NDEV'(1) << idx;

  always_comb begin
    s1   = '0;
    s2   = '0;
    data = '0;
    if (active) begin
      case (op)
        OP_LOAD:   begin s1 = dev_sel; data = word; end
        OP_UPDATE: begin s2 = dev_sel; data = word; end
        OP_SINGLE: begin s1 = dev_sel; s2 = dev_sel; data = word; end
        OP_BCAST: begin
          if (upd_phase) s2 = '1;
          else begin
            s1   = idx_sel;
            data = bwords[idx*DW +: DW];
          end
        end
        default: ;
      endcase
    end
  end

  assign bus_data    = data;
  assign stage1_en_n = ~s1;
  assign stage2_en_n = ~s2;
  assign strobe_n    = (state != ST_STROBE);
  assign clear_n     = (state != ST_CLEAR);

endmodule

// File: rtl/dac_strobe_seq.sv
`timescale 1ns/1ps
module dac_strobe_seq
  import dac_seq_pkg::*;
#(
  parameter int unsigned NDEV           = 4,
  parameter int unsigned DW             = 16,
  parameter int unsigned CLK_PS         = 5000,
  parameter int unsigned T_SETUP_PS     = 50000,
  parameter int unsigned T_STROBE_PS    = 50000,
  parameter int unsigned T_STROBE_SB_PS = 80000,
  parameter int unsigned T_HOLD_PS      = 10000,
  parameter int unsigned T_CLEAR_PS     = 200000,
  localparam int unsigned DEVW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [DEVW-1:0]    cmd_dev,
  input  logic [DW-1:0]      cmd_word,
  input  logic [NDEV*DW-1:0] cmd_bcast_words,
  output logic [DW-1:0]      bus_data,
  output logic [NDEV-1:0]    stage1_en_n,
  output logic [NDEV-1:0]    stage2_en_n,
  output logic               strobe_n,
  output logic               clear_n
);

  localparam int unsigned N_SETUP = ps_to_cycles(T_SETUP_PS, CLK_PS);
  localparam int unsigned N_STRB  = ps_to_cycles(T_STROBE_PS, CLK_PS);
  localparam int unsigned N_STRSB = ps_to_cycles(T_STROBE_SB_PS, CLK_PS);
  localparam int unsigned N_HOLD  = ps_to_cycles(T_HOLD_PS, CLK_PS);
  localparam int unsigned N_CLR   = ps_to_cycles(T_CLEAR_PS, CLK_PS);
  localparam int unsigned N_MAX12 = (N_SETUP > N_STRB) ? N_SETUP : N_STRB;
  localparam int unsigned N_MAX34 = (N_STRSB > N_HOLD) ? N_STRSB : N_HOLD;
  localparam int unsigned N_MAXA  = (N_MAX12 > N_MAX34) ? N_MAX12 : N_MAX34;
  localparam int unsigned N_MAX   = (N_MAXA > N_CLR) ? N_MAXA : N_CLR;
  localparam int unsigned CW      = $clog2(N_MAX + 1);

  seq_state_e         state_q, state_d;
  logic [2:0]         op_q;
  logic [DEVW-1:0]    dev_q, idx_q, idx_d;
  logic               upd_q, upd_d;
  logic [DW-1:0]      word_q;
  logic [NDEV*DW-1:0] bw_q;

  logic          accept, t_load, t_done;
  logic [CW-1:0] t_val;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  dac_seq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  // next-state and phase-counter loading
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    upd_d   = upd_q;
    t_load  = 1'b0;
    t_val   = '0;
    case (state_q)
      ST_IDLE: begin
        idx_d = '0;
        upd_d = 1'b0;
        if (accept) begin
          case (cmd_op)
            OP_CLEAR: begin
              state_d = ST_CLEAR;
              t_load  = 1'b1;
              t_val   = CW'(N_CLR - 1);
            end
            OP_LOAD, OP_UPDATE, OP_SINGLE, OP_BCAST: begin
              state_d = ST_SETUP;
              t_load  = 1'b1;
              t_val   = CW'(N_SETUP - 1);
            end
            default: ;
          endcase
        end
      end
      ST_SETUP: if (t_done) begin
        state_d = ST_STROBE;
        t_load  = 1'b1;
        t_val   = (op_q == OP_SINGLE) ? CW'(N_STRSB - 1) : CW'(N_STRB - 1);
      end
      ST_STROBE: if (t_done) begin
        state_d = ST_HOLD;
        t_load  = 1'b1;
        t_val   = CW'(N_HOLD - 1);
      end
      ST_HOLD: if (t_done) begin
        if ((op_q == OP_BCAST) && !upd_q) begin
          if (idx_q == DEVW'(NDEV - 1)) upd_d = 1'b1;
          else                          idx_d = idx_q + 1'b1;
          state_d = ST_SETUP;
          t_load  = 1'b1;
          t_val   = CW'(N_SETUP - 1);
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_CLEAR: if (t_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      upd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      upd_q   <= upd_d;
    end
  end

  // command capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      dev_q  <= '0;
      word_q <= '0;
      bw_q   <= '0;
    end else if (accept) begin
      op_q   <= cmd_op;
      dev_q  <= cmd_dev;
      word_q <= cmd_word;
      bw_q   <= cmd_bcast_words;
    end
  end

  dac_seq_pins #(.NDEV(NDEV), .DW(DW), .DEVW(DEVW)) u_pins (
    .state       (state_q),
    .op          (op_q),
    .dev         (dev_q),
    .idx         (idx_q),
    .upd_phase   (upd_q),
    .word        (word_q),
    .bwords      (bw_q),
    .bus_data    (bus_data),
    .stage1_en_n (stage1_en_n),
    .stage2_en_n (stage2_en_n),
    .strobe_n    (strobe_n),
    .clear_n     (clear_n)
  );

  // R3: the strobe only ever falls with some stage enabled
  p_strobe_has_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> ((stage1_en_n != '1) || (stage2_en_n != '1)));

  // R7: while clearing, no write activity
  p_clear_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |-> (strobe_n && (stage1_en_n == '1) && (stage2_en_n == '1)));

  // R8: never ready while a strobe or clear pulse is on the pins
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n || !clear_n) |-> !cmd_ready);

  // R6: at most one first-stage enable low at a time
  p_one_load_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~stage1_en_n));

  // R10: bus and enables hold through the strobe rising edge
  p_hold_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n) |-> ($stable(bus_data) && $stable(stage1_en_n) && $stable(stage2_en_n)));

  // R10: bus does not move while the strobe is low
  p_bus_steady_in_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && $past(!strobe_n)) |-> $stable(bus_data));

endmodule

// File: tb/dac_strobe_seq_test.sv
`timescale 1ns/1ps
module dac_strobe_seq_test;

  localparam int NDEV = 4;
  localparam int DW   = 16;
  localparam int CLKP = 5000;
  localparam int S  = (50000  + CLKP - 1) / CLKP;
  localparam int PD = (50000  + CLKP - 1) / CLKP;
  localparam int PS = (80000  + CLKP - 1) / CLKP;
  localparam int H  = (10000  + CLKP - 1) / CLKP;
  localparam int C  = (200000 + CLKP - 1) / CLKP;
  localparam int PW = 3 + 2 * NDEV + DW;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic cmd_ready;
  logic [2:0] cmd_op;
  logic [1:0] cmd_dev;
  logic [DW-1:0] cmd_word;
  logic [NDEV*DW-1:0] cmd_bcast_words;
  logic [DW-1:0] bus_data;
  logic [NDEV-1:0] stage1_en_n, stage2_en_n;
  logic strobe_n, clear_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  dac_strobe_seq uut (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_op (cmd_op), .cmd_dev (cmd_dev), .cmd_word (cmd_word),
    .cmd_bcast_words (cmd_bcast_words),
    .bus_data (bus_data), .stage1_en_n (stage1_en_n), .stage2_en_n (stage2_en_n),
    .strobe_n (strobe_n), .clear_n (clear_n)
  );

  function automatic logic [PW-1:0] act_pins();
    return {cmd_ready, strobe_n, clear_n, stage1_en_n, stage2_en_n, bus_data};
  endfunction

  function automatic int seq_len(input int op);
    case (op)
      0, 1: return S + PD + H;
      2:    return S + PS + H;
      3:    return C;
      4:    return (NDEV + 1) * (S + PD + H);
      default: return 0;
    endcase
  endfunction

  // expected pins in cycle k after acceptance
  function automatic logic [PW-1:0] exp_pins(input int op, input int dev, input logic [DW-1:0] w,
                                             input logic [NDEV*DW-1:0] bw, input int k);
    logic rdy, st, cl;
    logic [NDEV-1:0] e1, e2;
    logic [DW-1:0] d;
    int p, t, seg, r;
    rdy = 1'b1; st = 1'b1; cl = 1'b1; e1 = '1; e2 = '1; d = '0;
    p = (op == 2) ? PS : PD;
    t = S + p + H;
    if (op == 3) begin
      if (k < C) begin rdy = 1'b0; cl = 1'b0; end
    end else if (op <= 2) begin
      if (k < t) begin
        rdy = 1'b0; d = w;
        if (op != 1) e1[dev] = 1'b0;
        if (op != 0) e2[dev] = 1'b0;
        st = !(k >= S && k < S + p);
      end
    end else if (op == 4) begin
      if (k < (NDEV + 1) * t) begin
        seg = k / t; r = k % t;
        rdy = 1'b0;
        st = !(r >= S && r < S + p);
        if (seg < NDEV) begin e1[seg] = 1'b0; d = bw[seg*DW +: DW]; end
        else e2 = '0;
      end
    end
    return {rdy, st, cl, e1, e2, d};
  endfunction

  task automatic issue(input int op, input int dev, input logic [DW-1:0] w,
                       input logic [NDEV*DW-1:0] bw);
    @(negedge clk);
    cmd_op = 3'(op); cmd_dev = 2'(dev); cmd_word = w; cmd_bcast_words = bw;
    cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic watch(input int op, input int dev, input logic [DW-1:0] w,
                       input logic [NDEV*DW-1:0] bw, input string req);
    bit ok = 1'b1;
    int bad_k = 0;
    logic [PW-1:0] a, e, fa, fe;
    fa = '0; fe = '0;
    for (int k = 0; k <= seq_len(op); k++) begin
      @(negedge clk);
      a = act_pins();
      e = exp_pins(op, dev, w, bw, k);
      if (ok && a !== e) begin ok = 1'b0; bad_k = k; fa = a; fe = e; end
    end
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s op%0d dev%0d cycle %0d: actual %h expected %h", req, op, dev, bad_k, fa, fe);
    end
  endtask

  function automatic logic [NDEV*DW-1:0] bset(input int seed);
    logic [NDEV*DW-1:0] v;
    for (int i = 0; i < NDEV; i++) v[i*DW +: DW] = DW'(16'h1F0F * (i + 1) + seed * 16'h0101);
    return v;
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] w;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_dev = '0; cmd_word = '0;
    cmd_bcast_words = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    n_tests++;
    if (act_pins() !== exp_pins(7, 0, '0, '0, 0)) begin
      n_fail++;
      $display("FAIL R1 reset: actual %h expected %h", act_pins(), exp_pins(7, 0, '0, '0, 0));
    end

    // R3 R4 R5 R10 R2: every single-device op on every device
    for (int op = 0; op <= 2; op++) begin
      for (int d = 0; d < NDEV; d++) begin
        w = (d == 0) ? 16'h7FFF : (d == 1) ? 16'h8000 : DW'(16'hA5C3 ^ (d * 16'h1357 + op));
        issue(op, d, w, '0);
        watch(op, d, w, '0, (op == 0) ? "R3/R10" : (op == 1) ? "R4/R10" : "R5/R2");
      end
    end

    // R6: broadcast, two word sets
    issue(4, 0, '0, bset(1));
    watch(4, 0, '0, bset(1), "R6");
    issue(4, 3, 16'hFFFF, bset(9));
    watch(4, 3, 16'hFFFF, bset(9), "R6");

    // R7 R2: clear width
    issue(3, 2, 16'h1234, '0);
    watch(3, 2, 16'h1234, '0, "R7/R2");

    // R9: undefined opcodes
    for (int op = 5; op <= 7; op++) begin
      issue(op, 1, 16'hBEEF, bset(3));
      watch(op, 1, 16'hBEEF, bset(3), "R9");
    end

    // R8: update held valid while a load runs
    issue(0, 1, 16'h0F0F, '0);
    cmd_op = 3'd1; cmd_dev = 2'd2; cmd_word = 16'h3C3C; cmd_valid = 1'b1;
    watch(0, 1, 16'h0F0F, '0, "R8");
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    watch(1, 2, 16'h3C3C, '0, "R8");

    // R8: clear queued during a single write does not cut it short
    issue(2, 3, 16'h5555, '0);
    cmd_op = 3'd3; cmd_dev = 2'd0; cmd_word = 16'h0000; cmd_valid = 1'b1;
    watch(2, 3, 16'h5555, '0, "R8");
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    watch(3, 0, 16'h0000, '0, "R8/R7");

    // R8: broadcast queued behind a broadcast
    issue(4, 0, '0, bset(5));
    cmd_op = 3'd4; cmd_bcast_words = bset(6); cmd_valid = 1'b1;
    watch(4, 0, '0, bset(5), "R8/R6");
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    watch(4, 0, '0, bset(6), "R8/R6");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule